// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

This unit performs the bit-field operations of a 64-bit integer pipeline that has a 32-bit compatibility mode. Each cycle it can accept one instruction word, the source operand and the present destination value. It returns the value to be written back to the destination register. An extract takes a field of the source and right-aligns it. An insert merges the low bits of the source into a field of the destination. Eight function codes select the operation. They differ in operand width and in whether a +32 bias is applied to the low position, to the high position or length, or to both.

The result, a destination write-enable and an illegal-operation flag are all registered, so they appear one clock after the operation is presented. The register file, the exception logic and the instruction fetch sit outside the unit.

Top module: `bf_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the registered outputs become `res_q` = 0, `rt_we_q` = 0 and `illegal_q` = 0.
- R2: Outputs follow the inputs of the previous rising edge. When `op_valid` was low, `rt_we_q` and `illegal_q` are 0 and `res_q` equals the `rt_val` that was presented.
- R3: The unit recognises an instruction only when bits [31:26] equal 011111 and bits [5:0] hold one of the eight function codes listed in R4 to R11. Bits [15:11] carry a 5-bit value A (the size field for extracts, the msb field for inserts), and bits [10:6] carry a 5-bit value B (the lsb field). Any other word gives no write, no illegal flag, and `res_q` equal to `rt_val`.
- R4: Function 000000 (word extract) takes bits B up to B+A of the source's low 32 bits and places them at bit 0. The 32-bit value is then sign-extended to 64 bits.
- R5: Function 000011 (doubleword extract) takes bits B up to B+A of the 64-bit source and places them at bit 0, with the upper bits cleared.
- R6: Function 000001 (long doubleword extract) takes A+33 bits starting at bit B and places them at bit 0.
- R7: Function 000010 (upper doubleword extract) takes A+1 bits starting at bit B+32 and places them at bit 0.
- R8: Function 000100 (word insert) replaces destination bits A..B with the low bits of the source shifted left by B. The low 32 bits are kept and sign-extended to 64.
- R9: Function 000111 (doubleword insert) replaces destination bits A..B of the 64-bit value with the source shifted left by B. All other bits are unchanged.
- R10: Function 000101 (wide doubleword insert) replaces destination bits A+32..B with the source shifted left by B.
- R11: Function 000110 (upper doubleword insert) replaces destination bits A+32..B+32 with the source shifted left by B+32.
- R12: If an insert's effective low position exceeds its effective high position, `rt_we_q` is 0 and `res_q` equals `rt_val`.
- R13: A doubleword function (000001, 000010, 000011, 000101, 000110, 000111) issued while `wide_en` is low gives `illegal_q` = 1, `rt_we_q` = 0 and `res_q` equal to `rt_val`. The two word functions stay legal with `wide_en` low.
- R14: An extract whose field reaches past bit 63 (past bit 31 for the word form) keeps only the bits up to that boundary. The missing upper bits are zero before any sign extension.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| rs_val | input | 64 | Source operand |
| rt_val | input | 64 | Current destination value |
| wide_en | input | 1 | 64-bit operations enabled |
| res_q | output | 64 | Registered result |
| rt_we_q | output | 1 | Registered destination write-enable |
| illegal_q | output | 1 | Registered illegal-operation flag |

## Verification
The hardest cases to reach are the edges of the position space. These are extract fields that run past the word boundary and must be cut off rather than wrapped, and insert ranges whose biased low end passes the high end so that the write is dropped. Random instruction words seldom land on either case. The stimulus therefore sweeps every (B, A) pair for each of the eight function codes, which visits every truncated extract and every inverted insert for every bias combination. Random operands are used on each vector. It adds sweeps with 64-bit operation disabled and with foreign opcode and function values.

// File: rtl/bf_pkg.sv
package bf_pkg;
  localparam int XLEN    = 64;
  localparam int HALF    = XLEN / 2;
  localparam int FIELD_W = 5;
  localparam int POS_W   = $clog2(XLEN) + 1;

  localparam logic [5:0] OPC_BITFIELD = 6'b011111;

  typedef enum logic [5:0] {
    FN_XTR_W     = 6'b000000,
    FN_XTR_DLONG = 6'b000001,
    FN_XTR_DUP   = 6'b000010,
    FN_XTR_D     = 6'b000011,
    FN_INS_W     = 6'b000100,
    FN_INS_DSPAN = 6'b000101,
    FN_INS_DUP   = 6'b000110,
    FN_INS_D     = 6'b000111
  } bf_fn_e;

  typedef struct packed {
    logic             hit;
    logic             is_ins;
    logic             is_word;
    logic [POS_W-1:0] lo;
    logic [POS_W-1:0] hi;
  } bf_ctl_t;
endpackage

// File: rtl/bf_decode.sv
module bf_decode
  import bf_pkg::*;
(
  input  logic [31:0] instr,
  output bf_ctl_t     ctl
);
  localparam logic [POS_W-1:0] BIAS = POS_W'(HALF);

  logic [POS_W-1:0] fa, fb;
  logic             unused_regs;

  assign fa = POS_W'(instr[15:11]);
  assign fb = POS_W'(instr[10:6]);
  assign unused_regs = ^instr[25:16];

  always_comb begin
    ctl     = '0;
    ctl.hit = (instr[31:26] == OPC_BITFIELD);
    unique case (instr[5:0])
      FN_XTR_W:     begin ctl.is_word = 1'b1; ctl.lo = fb;        ctl.hi = fb + fa; end
      FN_XTR_D:     begin                     ctl.lo = fb;        ctl.hi = fb + fa; end
      FN_XTR_DLONG: begin                     ctl.lo = fb;        ctl.hi = fb + fa + BIAS; end
      FN_XTR_DUP:   begin                     ctl.lo = fb + BIAS; ctl.hi = fb + fa + BIAS; end
      FN_INS_W:     begin ctl.is_ins = 1'b1; ctl.is_word = 1'b1; ctl.lo = fb; ctl.hi = fa; end
      FN_INS_D:     begin ctl.is_ins = 1'b1; ctl.lo = fb;        ctl.hi = fa; end
      FN_INS_DSPAN: begin ctl.is_ins = 1'b1; ctl.lo = fb;        ctl.hi = fa + BIAS; end
      FN_INS_DUP:   begin ctl.is_ins = 1'b1; ctl.lo = fb + BIAS; ctl.hi = fa + BIAS; end
      default:      ctl.hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/bf_mask.sv
module bf_mask
  import bf_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [POS_W-1:0] lo,
  input  logic [POS_W-1:0] hi,
  input  logic [POS_W-1:0] limit,
  output logic [W-1:0]     mask
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    localparam logic [POS_W-1:0] IDX = POS_W'(g);
    assign mask[g] = (IDX >= lo) && (IDX <= hi) && (IDX < limit);
  end
endmodule

// File: rtl/bf_extract.sv
module bf_extract
  import bf_pkg::*;
#(
  parameter int W = XLEN,
  parameter int H = HALF
) (
  input  logic [W-1:0]     src,
  input  logic [W-1:0]     mask,
  input  logic [POS_W-1:0] lo,
  input  logic             is_word,
  output logic [W-1:0]     out
);
  logic [W-1:0] raw;
  assign raw = (src & mask) >> lo;
  assign out = is_word ? {{(W-H){raw[H-1]}}, raw[H-1:0]} : raw;
endmodule

// File: rtl/bf_insert.sv
module bf_insert
  import bf_pkg::*;
#(
  parameter int W = XLEN,
  parameter int H = HALF
) (
  input  logic [W-1:0]     dst,
  input  logic [W-1:0]     src,
  input  logic [W-1:0]     mask,
  input  logic [POS_W-1:0] lo,
  input  logic             is_word,
  output logic [W-1:0]     out
);
  logic [W-1:0] merged;
  assign merged = dst ^ ((dst ^ (src << lo)) & mask);
  assign out    = is_word ? {{(W-H){merged[H-1]}}, merged[H-1:0]} : merged;
endmodule

// File: rtl/bf_unit.sv
module bf_unit
  import bf_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  input  logic            wide_en,
  output logic [XLEN-1:0] res_q,
  output logic            rt_we_q,
  output logic            illegal_q
);
  bf_ctl_t          ctl;
  logic [POS_W-1:0] limit;
  logic [XLEN-1:0]  mask, ext_out, ins_out, res_n;
  logic             go, wide_bad, inverted, we_n, ill_n, word_q;

  bf_decode u_dec (.instr(instr), .ctl(ctl));

  assign limit = ctl.is_word ? POS_W'(HALF) : POS_W'(XLEN);

  bf_mask #(.W(XLEN)) u_mask (.lo(ctl.lo), .hi(ctl.hi), .limit(limit), .mask(mask));

  bf_extract #(.W(XLEN), .H(HALF)) u_ext (
    .src(rs_val), .mask(mask), .lo(ctl.lo), .is_word(ctl.is_word), .out(ext_out));

  bf_insert #(.W(XLEN), .H(HALF)) u_ins (
    .dst(rt_val), .src(rs_val), .mask(mask), .lo(ctl.lo), .is_word(ctl.is_word),
    .out(ins_out));

  always_comb begin
    go       = op_valid && ctl.hit;
    wide_bad = !ctl.is_word && !wide_en;
    inverted = ctl.is_ins && (ctl.lo > ctl.hi);
    we_n     = go && !wide_bad && !inverted;
    ill_n    = go && wide_bad;
    res_n    = !we_n ? rt_val : (ctl.is_ins ? ins_out : ext_out);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q     <= '0;
      rt_we_q   <= 1'b0;
      illegal_q <= 1'b0;
      word_q    <= 1'b0;
    end else begin
      res_q     <= res_n;
      rt_we_q   <= we_n;
      illegal_q <= ill_n;
      word_q    <= go && ctl.is_word;
    end
  end

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(op_valid) |-> (!rt_we_q && !illegal_q));

  // R12 and R13: every suppressed write passes the destination through
  assert_hold_dest_R12: assert property (@(posedge clk) disable iff (rst)
    (!rt_we_q && !$past(rst)) |-> (res_q == $past(rt_val)));

  assert_wide_gate_R13: assert property (@(posedge clk) disable iff (rst)
    illegal_q |-> (!$past(wide_en) && !rt_we_q));

  // R4 and R8: word forms leave a sign-extended result
  assert_word_sext_R4: assert property (@(posedge clk) disable iff (rst)
    (rt_we_q && word_q) |-> (res_q[XLEN-1:HALF] == {(XLEN-HALF){res_q[HALF-1]}}));
endmodule

// File: tb/test_bf_unit.sv
module test_bf_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] rs_val = '0;
  logic [63:0] rt_val = '0;
  logic        wide_en = 1'b1;
  logic [63:0] res_q;
  logic        rt_we_q, illegal_q;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bf_unit i_bf_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .instr(instr), .rs_val(rs_val),
    .rt_val(rt_val), .wide_en(wide_en), .res_q(res_q), .rt_we_q(rt_we_q),
    .illegal_q(illegal_q));

  function automatic logic [31:0] mk(input logic [5:0] fn, input int a, input int b);
    return {6'b011111, 5'd3, 5'd7, a[4:0], b[4:0], fn};
  endfunction

  // Reference built from the requirement text: positions and lengths, then shifts.
  task automatic predict(input logic v, input logic [31:0] ins, input logic [63:0] rs,
                         input logic [63:0] rt, input logic w,
                         output logic [63:0] e_res, output logic e_we, output logic e_ill,
                         output string tag);
    int a, b, lo, hi, len, lim;
    logic word, isins, known;
    logic [63:0] m, src, val;
    a = int'(ins[15:11]); b = int'(ins[10:6]);
    e_res = rt; e_we = 0; e_ill = 0; tag = "R3";
    known = 1; word = 0; isins = 0; lo = 0; hi = 0; len = 0;
    case (ins[5:0])
      6'b000000: begin word = 1; lo = b; len = a + 1; tag = "R4"; end
      6'b000011: begin lo = b; len = a + 1; tag = "R5"; end
      6'b000001: begin lo = b; len = a + 33; tag = "R6"; end
      6'b000010: begin lo = b + 32; len = a + 1; tag = "R7"; end
      6'b000100: begin isins = 1; word = 1; lo = b; hi = a; tag = "R8"; end
      6'b000111: begin isins = 1; lo = b; hi = a; tag = "R9"; end
      6'b000101: begin isins = 1; lo = b; hi = a + 32; tag = "R10"; end
      6'b000110: begin isins = 1; lo = b + 32; hi = a + 32; tag = "R11"; end
      default: known = 0;
    endcase
    if (!v) begin tag = "R2"; return; end
    if (ins[31:26] != 6'b011111 || !known) begin tag = "R3"; return; end
    if (!word && !w) begin e_ill = 1; tag = "R13"; return; end
    lim = word ? 32 : 64;
    if (!isins) begin
      if (lo + len > lim) begin len = lim - lo; tag = "R14"; end
      m = (len >= 64) ? {64{1'b1}} : ((64'd1 << len) - 64'd1);
      src = word ? {32'd0, rs[31:0]} : rs;
      val = (src >> lo) & m;
    end else begin
      if (lo > hi) begin tag = "R12"; return; end
      m = ({64{1'b1}} << lo) & ({64{1'b1}} >> (63 - hi));
      val = (rt & ~m) | ((rs << lo) & m);
    end
    if (word) val = {{32{val[31]}}, val[31:0]};
    e_res = val; e_we = 1;
  endtask

  task automatic apply(input logic v, input logic [31:0] ins, input logic [63:0] rs,
                       input logic [63:0] rt, input logic w);
    logic [63:0] e_res; logic e_we, e_ill; string tag;
    predict(v, ins, rs, rt, w, e_res, e_we, e_ill, tag);
    op_valid = v; instr = ins; rs_val = rs; rt_val = rt; wide_en = w;
    @(posedge clk); #1;
    n_vec++;
    if (res_q !== e_res || rt_we_q !== e_we || illegal_q !== e_ill) begin
      n_bad++;
      $display("FAIL %s instr=%h res=%h we=%b ill=%b expected res=%h we=%b ill=%b",
               tag, ins, res_q, rt_we_q, illegal_q, e_res, e_we, e_ill);
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    logic [5:0] fns [8];
    fns = '{6'b000000, 6'b000011, 6'b000001, 6'b000010,
            6'b000100, 6'b000111, 6'b000101, 6'b000110};
    rst = 1'b1; op_valid = 1'b1; instr = mk(6'b000111, 31, 0);
    rs_val = '1; rt_val = '1;
    repeat (3) @(posedge clk);
    #1;
    n_vec++;
    if (res_q !== 64'd0 || rt_we_q !== 1'b0 || illegal_q !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset res=%h we=%b ill=%b expected res=0 we=0 ill=0",
               res_q, rt_we_q, illegal_q);
    end
    rst = 1'b0;
    // R4 to R12 and R14: every (B, A) pair for every function code
    for (int f = 0; f < 8; f++)
      for (int b = 0; b < 32; b++)
        for (int a = 0; a < 32; a++)
          apply(1'b1, mk(fns[f], a, b), rnd64(), rnd64(), 1'b1);
    // R13: 64-bit operation disabled; word forms remain legal
    for (int f = 0; f < 8; f++)
      for (int k = 0; k < 16; k++)
        apply(1'b1, mk(fns[f], k * 2, 31 - k), rnd64(), rnd64(), 1'b0);
    // R3: foreign function codes and foreign opcodes
    for (int k = 8; k < 64; k++)
      apply(1'b1, mk(6'(k), k % 32, 3), rnd64(), rnd64(), 1'b1);
    for (int k = 0; k < 16; k++)
      apply(1'b1, {6'(k * 3), mk(fns[k % 8], 5, 2)[25:0]}, rnd64(), rnd64(), 1'b1);
    // R2: nothing presented
    for (int k = 0; k < 16; k++)
      apply(1'b0, mk(fns[k % 8], 9, 4), rnd64(), rnd64(), 1'b1);
    // R14 and R8 corner patterns with all-ones and alternating operands
    apply(1'b1, mk(6'b000000, 31, 0), 64'hFFFF_FFFF_8000_0000, 64'd0, 1'b1);
    apply(1'b1, mk(6'b000001, 31, 31), 64'hAAAA_5555_F0F0_0F0F, 64'd0, 1'b1);
    apply(1'b1, mk(6'b000100, 31, 31), 64'd1, 64'h0000_0000_0000_0000, 1'b1);
    apply(1'b1, mk(6'b000110, 31, 0), {64{1'b1}}, 64'd0, 1'b1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired after %0d vectors, expected completion", n_vec);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule